// File: doc/BRIEF.md
# Clocked-Burst NOR Flash Bus Front-End

This block is the device-side bus front-end of a NOR-style flash memory, built over a small register array. It takes the usual active-low controls: chip select `ce_n`, output enable `oe_n`, write strobe `we_n`, address-valid strobe `adv_n` and hardware reset `rst_n`. A clock `clk` drives all of its internal state. One address-valid strobe captures the read address for both of its read styles. In asynchronous mode the selected word is presented after an access latency and then held. In synchronous mode the block streams one word per rising clock edge, either without end or as a wrapped linear burst of fixed length.

The address space has two halves, chosen by the top address bit. The lower half is the word array. The upper half reads and writes a 3-bit mode register that selects synchronous operation and the burst length. Any write ends the access in progress. Access latency is a parameter counted in clock edges. A ready output marks every cycle in which the data bus carries a valid word.

Top module: `flash_burst_front`

## Requirements
- R1: After reset the mode register holds 0, which selects asynchronous reads and the continuous code. A read of any upper-half address (address MSB = 1) returns the mode register zero-extended to 16 bits.
- R2: An access is loaded on a rising edge where `ce_n`=0, `we_n`=1 and `adv_n`=0, and it captures `addr`. In asynchronous mode (mode bit 2 = 0), `rdy` rises LAT edges after the last load edge, with the addressed word on `dq_out`. Both then stay unchanged until a new event occurs.
- R3: `dq_oe` is 1 exactly when `rst_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1. When `dq_oe` is 0 the bus is released.
- R4: While `ce_n`=1, `rdy` is 0 and writes and loads are ignored. The first rising edge with `ce_n`=1 ends any access, so `rdy` stays 0 after `ce_n` returns low until a new load.
- R5: `rst_n`=0 clears `rdy` at once, ends any burst, and returns the mode register to 0.
- R6: A rising edge with `ce_n`=0 and `we_n`=0 is a write. When the address MSB is 0, the edge stores `dq_in` at array word `addr[AW-2:0]`. Every write ends the access in progress.
- R7: A write with the address MSB at 1 stores `dq_in[2:0]` into the mode register. Bit 2 set selects synchronous bursts. Bits 1:0 select the burst: 00 is continuous, 01 is 4 words, 10 is 8 words, 11 is 16 words.
- R8: In synchronous mode the first word appears with `rdy`=1 LAT edges after the load edge. Each later rising edge moves to the next burst address.
- R9: A continuous burst steps the address by 1 modulo 2^AW, crossing into the mode half and back to 0, and never stops on its own.
- R10: A linear burst of length L starts at the loaded address and wraps within the L-aligned block. It delivers exactly L words, after which `rdy` falls.
- R11: A new load during a burst abandons the old burst. `rdy` drops, and the new burst starts at the new address after LAT edges.
- R12: `dq_out` is 0 whenever `rdy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge is active |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr | input | AW | Word address; the MSB selects the mode register |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data, 0 when no word is valid |
| dq_oe | output | 1 | Data bus drive enable |
| rdy | output | 1 | Current word on `dq_out` is valid |

## Verification
The assertions assume the host keeps `we_n` and `adv_n` apart from any change of the mode register. In practice the mode only changes through a write, and a write always restarts the sequencer. The assertions also assume the latency parameter is at least 1. The stimulus changes every input only at the falling clock edge, so each rising edge sees settled controls. Writes and loads are issued as full-cycle pulses. Random starting addresses, burst codes and array contents are drawn with a fixed seed, and directed cases cover block wrap, the crossing into the mode half, restart, standby abort and reset mid-burst.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_WAIT   = 2'd1,
    SEQ_STREAM = 2'd2,
    SEQ_DONE   = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    WRAP_NONE = 2'd0,
    WRAP_4    = 2'd1,
    WRAP_8    = 2'd2,
    WRAP_16   = 2'd3
  } wrap_t;

  typedef struct packed {
    logic  sync;
    wrap_t wrap;
  } mode_t;

  localparam int BEAT_W = 5;

  // burst length in words for a wrap code, 0 for continuous
  function automatic logic [BEAT_W-1:0] wrap_len(wrap_t w);
    case (w)
      WRAP_4:  wrap_len = BEAT_W'(4);
      WRAP_8:  wrap_len = BEAT_W'(8);
      WRAP_16: wrap_len = BEAT_W'(16);
      default: wrap_len = '0;
    endcase
  endfunction

endpackage

// File: rtl/fbf_array.sv
module fbf_array #(
  parameter int IDX_W = 6,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/fbf_mode_reg.sv
module fbf_mode_reg
  import fbf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  mode_t wr_mode,
  output mode_t mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '{sync: 1'b0, wrap: WRAP_NONE};
    else if (wr_en) mode_q <= wr_mode;
  end

  // R7: the mode only changes through a mode write
  a_r7_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode_q));

endmodule

// File: rtl/fbf_burst_seq.sv
module fbf_burst_seq
  import fbf_pkg::*;
#(
  parameter int AW  = 7,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          load_ev,
  input  logic          wr_ev,
  input  mode_t         mode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] cur_addr,
  output logic          word_valid
);
  localparam int LAT_W = (LAT > 1) ? $clog2(LAT) : 1;

  seq_state_t          st;
  logic [LAT_W-1:0]    lat_cnt;
  logic [BEAT_W-1:0]   beat;
  logic [BEAT_W-1:0]   len;
  logic                linear;
  logic                last_beat;
  logic                abort_ev;
  logic                step_ev;

  // next address inside the aligned wrap block (whole space when continuous)
  function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a, wrap_t w);
    logic [AW-1:0] m;
    m = (w == WRAP_NONE) ? '1 : AW'(wrap_len(w) - BEAT_W'(1));
    step_addr = (a & ~m) | ((a + AW'(1)) & m);
  endfunction

  assign len       = wrap_len(mode.wrap);
  assign linear    = (mode.wrap != WRAP_NONE);
  assign last_beat = linear && (beat == len - BEAT_W'(1));
  assign abort_ev  = ce_n || wr_ev;
  assign step_ev   = !abort_ev && !load_ev && (st == SEQ_STREAM) && mode.sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SEQ_IDLE;
      cur_addr <= '0;
      lat_cnt  <= '0;
      beat     <= '0;
    end else if (abort_ev) begin
      st   <= SEQ_IDLE;
      beat <= '0;
    end else if (load_ev) begin
      st       <= SEQ_WAIT;
      cur_addr <= addr_in;
      lat_cnt  <= LAT_W'(LAT - 1);
      beat     <= '0;
    end else begin
      case (st)
        SEQ_WAIT: begin
          if (lat_cnt == '0) st <= SEQ_STREAM;
          else lat_cnt <= lat_cnt - LAT_W'(1);
        end
        SEQ_STREAM: begin
          if (step_ev) begin
            if (last_beat) begin
              st <= SEQ_DONE;
            end else begin
              cur_addr <= step_addr(cur_addr, mode.wrap);
              if (linear) beat <= beat + BEAT_W'(1);
            end
          end
        end
        default: st <= st;
      endcase
    end
  end

  assign word_valid = !ce_n && (st == SEQ_STREAM);

  // R8: a load always enters the latency phase
  a_r8_load_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !abort_ev) |=> (st == SEQ_WAIT) && (cur_addr == $past(addr_in)));

  // R2: an asynchronous access holds its word
  a_r2_async_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_STREAM && !mode.sync && !abort_ev && !load_ev)
      |=> $stable(cur_addr) && (st == SEQ_STREAM));

  // R9: each streamed edge moves to the next address of the burst
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !last_beat) |=> cur_addr == step_addr($past(cur_addr), $past(mode.wrap)));

  // R10: a linear burst never runs past its length
  a_r10_linear_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SEQ_STREAM && linear) |-> (beat < len));

  // R4: standby ends the access
  a_r4_standby_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (st == SEQ_IDLE) && !word_valid);

  // R6: a write ends the access
  a_r6_write_abort: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ev |=> (st == SEQ_IDLE));

endmodule

// File: rtl/flash_burst_front.sv
module flash_burst_front
  import fbf_pkg::*;
#(
  parameter int AW  = 7,
  parameter int DW  = 16,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          rdy
);
  localparam int IDX_W = AW - 1;

  logic          load_ev;
  logic          wr_ev;
  logic          mem_wr;
  logic          mode_wr;
  mode_t         mode_q;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] mem_word;
  logic [DW-1:0] sel_word;
  logic          word_valid;

  assign load_ev = !ce_n && we_n && !adv_n;
  assign wr_ev   = !ce_n && !we_n;
  assign mem_wr  = wr_ev && !addr[AW-1];
  assign mode_wr = wr_ev && addr[AW-1];

  fbf_array #(.IDX_W(IDX_W), .DW(DW)) u_array (
    .clk     (clk),
    .wr_en   (mem_wr),
    .wr_idx  (addr[IDX_W-1:0]),
    .wr_data (dq_in),
    .rd_idx  (cur_addr[IDX_W-1:0]),
    .rd_data (mem_word)
  );

  fbf_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mode_wr),
    .wr_mode (mode_t'(dq_in[2:0])),
    .mode_q  (mode_q)
  );

  fbf_burst_seq #(.AW(AW), .LAT(LAT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .load_ev    (load_ev),
    .wr_ev      (wr_ev),
    .mode       (mode_q),
    .addr_in    (addr),
    .cur_addr   (cur_addr),
    .word_valid (word_valid)
  );

  assign sel_word = cur_addr[AW-1] ? {{(DW-3){1'b0}}, mode_q} : mem_word;
  assign rdy      = word_valid;
  assign dq_out   = word_valid ? sel_word : '0;
  assign dq_oe    = rst_n && !ce_n && !oe_n && we_n;

  // R3: the bus is never driven in standby or during a write
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || !we_n) |-> !dq_oe);

  // R12: an idle bus carries zero
  a_r12_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> (dq_out == '0));

endmodule

// File: tb/sim_flash_burst_front.sv
module sim_flash_burst_front;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 7;
  localparam int DW  = 16;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, adv_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in, dq_out;
  logic dq_oe, rdy;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_mem [64];
  logic [2:0]    ref_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_burst_front #(.AW(AW), .DW(DW), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .adv_n(adv_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .rdy(rdy)
  );

  function automatic logic [DW-1:0] exp_word(logic [AW-1:0] a);
    if (a >= 7'd64) return {13'd0, ref_mode};
    return ref_mem[a % 64];
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] start, int k, int code);
    int span, base, off;
    if (code == 0) return AW'((int'(start) + k) % 128);
    span = 2 << code;
    off  = int'(start) % span;
    base = int'(start) - off;
    return AW'(base + (off + k) % span);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; adv_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; adv_n = 1'b1; addr = a; dq_in = d;
    @(negedge clk);
    bus_idle();
    if (a >= 7'd64) ref_mode = d[2:0];
    else ref_mem[a % 64] = d;
  endtask

  task automatic load(input logic [AW-1:0] a);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; adv_n = 1'b0; addr = a;
    @(negedge clk);
    adv_n = 1'b1; addr = AW'($urandom);
  endtask

  task automatic async_read(input logic [AW-1:0] a, input string req);
    load(a);
    repeat (LAT - 1) @(negedge clk);
    chk({req, " latency rdy low"}, 32'(rdy), 32'd0);
    @(negedge clk);
    chk({req, " rdy"}, 32'(rdy), 32'd1);
    chk({req, " data"}, 32'(dq_out), 32'(exp_word(a)));
    repeat (2) @(negedge clk);
    chk({req, " R2 hold"}, 32'(dq_out), 32'(exp_word(a)));
  endtask

  task automatic burst(input logic [AW-1:0] start, input int code, input int nwords);
    int span;
    span = (code == 0) ? nwords : (2 << code);
    load(start);
    repeat (LAT - 1) @(negedge clk);
    chk("R8 latency rdy low", 32'(rdy), 32'd0);
    for (int k = 0; k < span; k++) begin
      @(negedge clk);
      chk("R8 rdy", 32'(rdy), 32'd1);
      chk(code == 0 ? "R9 word" : "R10 word", 32'(dq_out), 32'(exp_word(exp_addr(start, k, code))));
    end
    if (code != 0) begin
      @(negedge clk);
      chk("R10 end rdy", 32'(rdy), 32'd0);
      chk("R12 idle zero", 32'(dq_out), 32'd0);
    end
  endtask

  initial begin
    int seed;
    logic [AW-1:0] a;
    seed = int'($urandom(32'h5EED1234));
    bus_idle();
    rst_n = 1'b0; addr = '0; dq_in = '0; ref_mode = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset rdy", 32'(rdy), 32'd0);
    chk("R4 standby bus", 32'(dq_oe), 32'd0);
    async_read(7'h40, "R1 mode read");

    // fill array
    for (int i = 0; i < 64; i++) wr(AW'(i), DW'($urandom));
    async_read(7'd0, "R6 write");
    async_read(7'd63, "R6 write");

    // R3 bus enable combinations
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; #1;
    chk("R3 oe on", 32'(dq_oe), 32'd1);
    oe_n = 1'b1; #1;
    chk("R3 oe off", 32'(dq_oe), 32'd0);
    oe_n = 1'b0; we_n = 1'b0; #1;
    chk("R3 write off", 32'(dq_oe), 32'd0);
    we_n = 1'b1; ce_n = 1'b1; #1;
    chk("R3 ce off", 32'(dq_oe), 32'd0);
    bus_idle();

    for (int i = 0; i < 6; i++) async_read(AW'($urandom % 64), "R2 async");

    // R4 standby write ignored
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b0; addr = 7'd5; dq_in = ~ref_mem[5];
    @(negedge clk);
    bus_idle();
    async_read(7'd5, "R4 ignored write");

    // directed linear wraps and continuous crossings
    wr(7'h40, 16'h0005); burst(7'd6, 1, 4);
    wr(7'h40, 16'h0006); burst(7'd13, 2, 8);
    wr(7'h40, 16'h0007); burst(7'd35, 3, 16);
    wr(7'h40, 16'h0004); burst(7'h3E, 0, 5);
    burst(7'h7E, 0, 5);

    // random bursts
    for (int i = 0; i < 20; i++) begin
      int code;
      code = int'($urandom % 4);
      wr(7'h40, DW'(4 + code));
      burst(AW'($urandom), code, 10);
    end

    // R11 restart mid burst
    wr(7'h40, 16'h0004);
    load(7'd10);
    repeat (LAT + 1) @(negedge clk);
    chk("R11 first burst", 32'(dq_out), 32'(exp_word(7'd11)));
    burst(7'd30, 0, 4);

    // R4 chip-enable abort
    @(negedge clk);
    ce_n = 1'b1; #1;
    chk("R4 abort rdy", 32'(rdy), 32'd0);
    chk("R12 abort zero", 32'(dq_out), 32'd0);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; #1;
    chk("R4 stays ended", 32'(rdy), 32'd0);
    @(negedge clk);
    chk("R4 stays ended later", 32'(rdy), 32'd0);
    bus_idle();

    // R5 reset mid burst
    wr(7'h40, 16'h0006);
    load(7'd20);
    repeat (LAT + 1) @(negedge clk);
    chk("R5 pre-reset rdy", 32'(rdy), 32'd1);
    rst_n = 1'b0; #1;
    chk("R5 reset rdy", 32'(rdy), 32'd0);
    chk("R5 reset bus", 32'(dq_oe), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_mode = 3'd0;
    bus_idle();
    async_read(7'h40, "R5 mode cleared");
    a = 7'd12;
    async_read(a, "R5 async after reset");

    bus_idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule